// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block takes in 8-bit frames from a clocked synchronous serial link. A serial clock and a serial data line come in from outside. Both pass through a synchronizer into the system clock domain. On every rising edge of the serial clock, one data bit is shifted into an internal shift register, least significant bit first. When the eighth bit arrives, the byte goes to a buffered data register. While that byte waits for the host, the next frame can already be shifting in, so reception can run without gaps.

The host clears the flags with single-cycle strobes. If a frame completes while the previous byte has not yet been released, the block signals an overrun. It then keeps the old byte, drops the new one and stops receiving. Reception starts again only after the overrun, the full flag and the externally supplied framing and parity error levels are all clear. Two interrupt levels, receive-complete and receive-error, are gated by one interrupt enable.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset the data output is 0x00 and the full flag, the overrun flag and both interrupt outputs are 0.
- R2: Eight rising edges of `ser_clk` with reception enabled and not stalled form one byte; the bit sampled at the first edge becomes bit 0. If the full flag was 0, the byte appears on `rx_data` and the full flag becomes 1.
- R3: If a byte completes while the full flag is 1, the overrun flag becomes 1, `rx_data` keeps the old byte and the full flag stays 1.
- R4: Once the overrun flag is set, serial edges are ignored until the overrun flag, the full flag and both error inputs are all 0 at the same time; clearing only the overrun flag is not enough.
- R5: While `frm_err_i` or `par_err_i` is 1, no byte is accepted and a partial frame is dropped.
- R6: `rxi_irq` is 1 exactly when the full flag is 1, `rx_ie` is 1 and the overrun flag is 0.
- R7: `eri_irq` is 1 exactly when `rx_ie` is 1 and at least one of overrun, `frm_err_i` or `par_err_i` is 1.
- R8: A one-cycle pulse on `clr_full` clears the full flag and a pulse on `clr_ovr` clears the overrun flag; neither strobe changes `rx_data`.
- R9: Driving `rx_en` low resets the bit count, so bits shifted before it went low do not appear in any later byte.
- R10: If the full flag is cleared before the next frame ends, frames sent back to back are all delivered in order without an overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receive enable; low drops any partial frame |
| rx_ie | input | 1 | Receive interrupt enable |
| ser_clk | input | 1 | External serial synchronization clock |
| ser_data | input | 1 | Serial data line, LSB first |
| frm_err_i | input | 1 | Framing error flag level, used only to stall reception |
| par_err_i | input | 1 | Parity error flag level, used only to stall reception |
| clr_full | input | 1 | Host strobe clearing the full flag |
| clr_ovr | input | 1 | Host strobe clearing the overrun flag |
| rx_data | output | 8 | Buffered received byte |
| full_flag | output | 1 | Receive-data-full flag |
| ovr_flag | output | 1 | Overrun flag |
| rxi_irq | output | 1 | Receive-complete interrupt level |
| eri_irq | output | 1 | Receive-error interrupt level |

## Verification
On every cycle the assertions check these invariants: the buffered byte stays unchanged when an overrun is raised, the full flag rises only after a completed frame, no frame completes while reception is stalled, and a synchronized clock edge never lasts more than one cycle. Several behaviours can only be shown by the bench's scenarios. These are the bit order and the byte values delivered, the rule that clearing only the overrun flag does not restart reception, the dropping of partial frames when the enable or an error input changes, and the delivery of back-to-back frames with no gap between them.

// File: rtl/srx_pkg.sv
package srx_pkg;
  parameter int unsigned SRX_BITS = 8;
  parameter int unsigned SRX_SYNC = 2;

  typedef struct packed {
    logic par;
    logic frm;
    logic ovr;
  } srx_err_t;
endpackage

// File: rtl/srx_rst_sync.sv
module srx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/srx_edge_sync.sv
module srx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic ser_clk,
  input  logic ser_data,
  output logic sclk_rise,
  output logic sdata
);
  logic [STAGES-1:0] clk_q, dat_q;
  logic              clk_prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) begin
            clk_q[g] <= 1'b0;
            dat_q[g] <= 1'b0;
          end else begin
            clk_q[g] <= ser_clk;
            dat_q[g] <= ser_data;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_ni) begin
          if (!rst_ni) begin
            clk_q[g] <= 1'b0;
            dat_q[g] <= 1'b0;
          end else begin
            clk_q[g] <= clk_q[g-1];
            dat_q[g] <= dat_q[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) clk_prev_q <= 1'b0;
    else         clk_prev_q <= clk_q[STAGES-1];
  end

  assign sclk_rise = clk_q[STAGES-1] & ~clk_prev_q;
  assign sdata     = dat_q[STAGES-1];

  // R2: a synchronized edge is a single-cycle event
  assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              rx_en,
  input  logic              blocked,
  input  logic              sclk_rise,
  input  logic              sdata,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_byte
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              run, take;

  assign run        = rx_en & ~blocked;
  assign take       = run & sclk_rise;
  assign frame_byte = {sdata, sh_q[DATA_W-1:1]};
  assign frame_done = take & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (!run) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (take) begin
      sh_d  = frame_byte;
      cnt_d = frame_done ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  // R9: disabling reception returns the bit count to zero
  assert_cnt_cleared_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    !rx_en |=> cnt_q == '0);
endmodule

// File: rtl/srx_status.sv
module srx_status #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_byte,
  input  logic              frm_err_i,
  input  logic              par_err_i,
  input  logic              clr_full,
  input  logic              clr_ovr,
  output logic              blocked,
  output logic              full_q,
  output logic              ovr_q,
  output logic [DATA_W-1:0] data_q
);
  import srx_pkg::*;

  srx_err_t          err;
  logic              err_any, halt_q, halt_d, full_d, ovr_d;
  logic [DATA_W-1:0] data_d;

  assign err     = '{par: par_err_i, frm: frm_err_i, ovr: ovr_q};
  assign err_any = |err;
  assign blocked = err_any | (halt_q & full_q);

  always_comb begin
    full_d = full_q;
    ovr_d  = ovr_q;
    data_d = data_q;
    if (clr_full) full_d = 1'b0;
    if (clr_ovr)  ovr_d  = 1'b0;
    if (frame_done) begin
      if (full_q) begin
        ovr_d = 1'b1;
      end else begin
        full_d = 1'b1;
        data_d = frame_byte;
      end
    end
    halt_d = err_any | (halt_q & full_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      halt_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      ovr_q  <= ovr_d;
      halt_q <= halt_d;
      data_q <= data_d;
    end
  end

  // R3: an overrun leaves the buffered byte and the full flag in place
  assert_ovr_keeps_byte_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ovr_q) |-> $stable(data_q) && full_q);
  // R2: the full flag rises only after a completed frame
  assert_full_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(full_q) |-> $past(frame_done));
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx #(
  parameter int unsigned DATA_W      = srx_pkg::SRX_BITS,
  parameter int unsigned SYNC_STAGES = srx_pkg::SRX_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_ie,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              frm_err_i,
  input  logic              par_err_i,
  input  logic              clr_full,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] rx_data,
  output logic              full_flag,
  output logic              ovr_flag,
  output logic              rxi_irq,
  output logic              eri_irq
);
  logic              rst_ni, sclk_rise, sdata, blocked, frame_done;
  logic [DATA_W-1:0] frame_byte;

  srx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_ni));

  srx_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_ni(rst_ni), .ser_clk(ser_clk), .ser_data(ser_data),
    .sclk_rise(sclk_rise), .sdata(sdata));

  srx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_ni(rst_ni), .rx_en(rx_en), .blocked(blocked),
    .sclk_rise(sclk_rise), .sdata(sdata),
    .frame_done(frame_done), .frame_byte(frame_byte));

  srx_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_ni(rst_ni), .frame_done(frame_done), .frame_byte(frame_byte),
    .frm_err_i(frm_err_i), .par_err_i(par_err_i),
    .clr_full(clr_full), .clr_ovr(clr_ovr),
    .blocked(blocked), .full_q(full_flag), .ovr_q(ovr_flag), .data_q(rx_data));

  assign rxi_irq = full_flag & rx_ie & ~ovr_flag;
  assign eri_irq = rx_ie & (ovr_flag | frm_err_i | par_err_i);

  // R4: no frame completes while reception is stalled
  assert_no_frame_when_stalled_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    ovr_flag |-> !frame_done);
  // R5: an error input stops frame completion
  assert_err_in_blocks_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (frm_err_i || par_err_i) |-> !frame_done);
endmodule

// File: tb/test_sync_serial_rx.sv
module test_sync_serial_rx;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic       clk, rst_n, rx_en, rx_ie, ser_clk, ser_data;
  logic       frm_err_i, par_err_i, clr_full, clr_ovr;
  logic [7:0] rx_data;
  logic       full_flag, ovr_flag, rxi_irq, eri_irq;

  int checks = 0;
  int bad    = 0;
  bit ended  = 0;
  logic [7:0] exp_q[$];

  sync_serial_rx i_sync_serial_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_ie(rx_ie),
    .ser_clk(ser_clk), .ser_data(ser_data),
    .frm_err_i(frm_err_i), .par_err_i(par_err_i),
    .clr_full(clr_full), .clr_ovr(clr_ovr),
    .rx_data(rx_data), .full_flag(full_flag), .ovr_flag(ovr_flag),
    .rxi_irq(rxi_irq), .eri_irq(eri_irq));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // monitor: every rise of the full flag must deliver the next expected byte
  logic prev_full = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (full_flag && !prev_full) begin
        checks++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R2 actual=%0h expected=none (unexpected byte)", rx_data);
        end else begin
          automatic logic [7:0] e = exp_q.pop_front();
          if (rx_data !== e) begin
            bad++;
            $display("FAIL R2 actual=%0h expected=%0h", rx_data, e);
          end
        end
      end
      prev_full = full_flag;
    end
  end

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      ser_data = b[i];
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b0;
    end
  endtask

  // driver: pushes the byte to the scoreboard when it is expected to land
  task automatic send_byte(input logic [7:0] b, input bit lands);
    if (lands) exp_q.push_back(b);
    send_bits(b, 8);
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_full();
    clr_full = 1'b1; @(negedge clk); clr_full = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_ovr();
    clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b1; rx_ie = 1'b1; ser_clk = 1'b0; ser_data = 1'b0;
    frm_err_i = 1'b0; par_err_i = 1'b0; clr_full = 1'b0; clr_ovr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 data", rx_data, 8'h00);
    check("R1 full", full_flag, 0);
    check("R1 ovr", ovr_flag, 0);
    check("R1 rxi", rxi_irq, 0);
    check("R1 eri", eri_irq, 0);

    // R2, R6: one good byte
    send_byte(8'hA5, 1);
    check("R2 full", full_flag, 1);
    check("R6 rxi set", rxi_irq, 1);
    check("R7 eri clear", eri_irq, 0);
    rx_ie = 1'b0; @(negedge clk);
    check("R6 rxi gated", rxi_irq, 0);
    rx_ie = 1'b1; @(negedge clk);

    // R8: clear full
    pulse_full();
    check("R8 full cleared", full_flag, 0);
    check("R8 data kept", rx_data, 8'hA5);
    check("R6 rxi off", rxi_irq, 0);

    // R3, R7: overrun
    send_byte(8'h3C, 1);
    send_byte(8'h5A, 0);
    check("R3 ovr", ovr_flag, 1);
    check("R3 data kept", rx_data, 8'h3C);
    check("R3 full stays", full_flag, 1);
    check("R7 eri", eri_irq, 1);
    check("R6 rxi masked by ovr", rxi_irq, 0);

    // R4: stalled
    send_byte(8'hFF, 0);
    check("R4 ignored while ovr", rx_data, 8'h3C);
    pulse_ovr();
    check("R8 ovr cleared", ovr_flag, 0);
    send_byte(8'h11, 0);
    check("R4 still stalled", ovr_flag, 0);
    check("R4 still stalled data", rx_data, 8'h3C);
    pulse_full();
    send_byte(8'h81, 1);
    check("R4 resumed", rx_data, 8'h81);
    pulse_full();

    // R5: error inputs stall
    frm_err_i = 1'b1; @(negedge clk);
    check("R7 eri from frm", eri_irq, 1);
    send_byte(8'h22, 0);
    check("R5 frm blocks", full_flag, 0);
    frm_err_i = 1'b0; par_err_i = 1'b1;
    send_bits(8'h0F, 4);
    par_err_i = 1'b0; @(negedge clk);
    send_byte(8'h44, 1);
    check("R5 partial dropped", rx_data, 8'h44);
    pulse_full();

    // R9: enable drop
    send_bits(8'hF0, 5);
    rx_en = 1'b0; repeat (3) @(negedge clk);
    rx_en = 1'b1; @(negedge clk);
    send_byte(8'h96, 1);
    check("R9 partial dropped", rx_data, 8'h96);
    pulse_full();

    // R10: back to back with clearing
    exp_q.push_back(8'h12);
    send_bits(8'h12, 8);
    repeat (6) @(negedge clk);
    clr_full = 1'b1; @(negedge clk); clr_full = 1'b0;
    exp_q.push_back(8'h34);
    send_bits(8'h34, 8);
    repeat (6) @(negedge clk);
    check("R10 no ovr", ovr_flag, 0);
    check("R10 second byte", rx_data, 8'h34);

    repeat (4) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule